// File: doc/BRIEF.md
# Multi-Size Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It holds recent virtual-to-physical page translations and answers a lookup one cycle after it is presented. Every entry records its own page size, so one table holds 4KB, 16KB, 64KB, 2MB and 512MB pages at the same time. A lookup compares all entries in parallel. For each entry, only the virtual address bits at or above that entry's page size take part in the compare.

Each entry is tagged with an address space identifier (ASID), a global flag, a virtual machine identifier (VMID) and a translation regime. Switching the current process or virtual machine therefore needs no flush: entries of other contexts simply fail to match. A lookup that misses raises a miss request that echoes the lookup key, so a second-level structure can start its own search. The translation that eventually returns is written through the fill port. Software-directed invalidation removes everything, the non-global entries of one ASID, or the entries of one VMID.

Top module: `tagged_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` and `miss_valid` are low, and every lookup misses.
- R2: A lookup presented with `lk_valid` high gets its response (`rsp_valid` high) on the cycle after it is presented. `rsp_valid` is low in any cycle that follows one without `lk_valid`.
- R3: `fill_size` codes 0, 1, 2, 3 and 4 select page sizes of 4KB, 16KB, 64KB, 2MB and 512MB. These have 12, 14, 16, 21 and 29 offset bits. Codes 5 to 7 behave as 4KB. Only VA bits at or above the entry's offset width are compared.
- R4: On a hit, `rsp_pa` holds the entry's physical bits above the offset width joined with the lookup VA's bits below it, and `rsp_attr` holds the entry's attribute bits.
- R5: A non-global entry hits only when its ASID equals `lk_asid`. An entry filled with `fill_global` high hits for any ASID.
- R6: A hit also requires the entry's VMID to equal `lk_vmid` and its regime to equal `lk_regime`.
- R7: A lookup that misses gives `rsp_hit` low and `miss_valid` high. In the same cycle, `miss_va`, `miss_asid`, `miss_vmid` and `miss_regime` equal the missed lookup's key. `miss_valid` stays low after a hit.
- R8: A fill is visible to a lookup presented in the cycle after the fill.
- R9: The fill target is chosen in this order:
  - First, the lowest-index valid entry with the same size, regime, VMID and global flag, the same ASID when non-global, and the same page. The fill overwrites this entry.
  - Otherwise, the lowest-index invalid entry.
  - Otherwise, the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such replacement only.
- R10: `inv_cmd` 1 clears every entry, 2 clears only non-global entries whose ASID equals `inv_asid`, and 3 clears entries whose VMID equals `inv_vmid`. Each takes effect within one cycle, and code 0 does nothing. A fill in the same cycle still validates its own target.
- R11: When more than one entry hits, `rsp_multi` is high and the PA and attributes come from the lowest-index hitting entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Current ASID |
| lk_vmid | input | VMID_W | Current VMID |
| lk_regime | input | RG_W | Current translation regime |
| fill_valid | input | 1 | Write a translation |
| fill_va | input | VA_W | Virtual address of the filled page |
| fill_pa | input | PA_W | Physical address of the filled page |
| fill_size | input | 3 | Page size code |
| fill_global | input | 1 | Entry matches any ASID |
| fill_asid | input | ASID_W | ASID of the filled page |
| fill_vmid | input | VMID_W | VMID of the filled page |
| fill_regime | input | RG_W | Regime of the filled page |
| fill_attr | input | ATTR_W | Attribute bits stored with the page |
| inv_cmd | input | 2 | Invalidate command: 0 none, 1 all, 2 by ASID, 3 by VMID |
| inv_asid | input | ASID_W | ASID for invalidate-by-ASID |
| inv_vmid | input | VMID_W | VMID for invalidate-by-VMID |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_multi | output | 1 | More than one entry hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_attr | output | ATTR_W | Attribute bits of the hit entry |
| miss_valid | output | 1 | Miss request toward the next level |
| miss_va | output | VA_W | Missed virtual address |
| miss_asid | output | ASID_W | Missed ASID |
| miss_vmid | output | VMID_W | Missed VMID |
| miss_regime | output | RG_W | Missed regime |

## Verification
A wrong valid bit or tag shows on the very next lookup to that page: a spurious hit, a miss with `miss_valid` raised, or the wrong PA. A wrong replacement pointer or duplicate decision stays hidden until the table is full. It then shows as an eviction of the wrong page, which a later lookup of the expected survivor exposes as a miss or as a `rsp_multi` flag. Because the bench mirrors the whole table and the pointer, the first lookup after a wrong eviction is caught. This is typically within a few operations.

// File: rtl/tagged_tlb_pkg.sv
// Shared encodings for the tagged TLB: page size codes, invalidate
// commands and the offset-width helper. Assumes sizes no larger than 512MB.
package tagged_tlb_pkg;

    typedef enum logic [2:0] {
        PG_4K   = 3'd0,
        PG_16K  = 3'd1,
        PG_64K  = 3'd2,
        PG_2M   = 3'd3,
        PG_512M = 3'd4
    } pg_size_e;

    typedef enum logic [1:0] {
        INV_NONE = 2'd0,
        INV_ALL  = 2'd1,
        INV_ASID = 2'd2,
        INV_VMID = 2'd3
    } inv_cmd_e;

    // Number of page-offset bits for a (normalised) size code.
    function automatic int unsigned page_shift(input logic [2:0] sz);
        case (pg_size_e'(sz))
            PG_16K:  return 14;
            PG_64K:  return 16;
            PG_2M:   return 21;
            PG_512M: return 29;
            default: return 12;
        endcase
    endfunction

    // Map reserved size codes onto the smallest page.
    function automatic logic [2:0] norm_size(input logic [2:0] sz);
        return (sz > 3'd4) ? 3'd0 : sz;
    endfunction

endpackage

// File: rtl/tlb_match_array.sv
// Entry storage and per-entry comparators. Every entry compares the lookup
// key (hit vector) and the fill key (duplicate vector) in parallel.
// Assumes wr_size is already normalised and PA_W >= 29.
module tlb_match_array
    import tagged_tlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16,
    parameter int ATTR_W = 8,
    parameter int RG_W   = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_va,
    input  logic [PA_W-1:0]   wr_pa,
    input  logic [2:0]        wr_size,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VMID_W-1:0] wr_vmid,
    input  logic [RG_W-1:0]   wr_regime,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [1:0]        inv_cmd,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VMID_W-1:0] inv_vmid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic [RG_W-1:0]   lk_regime,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [N-1:0]      hit_vec,
    output logic [N-1:0]      dup_vec,
    output logic [N-1:0]      valid_vec,
    output logic [PA_W-1:0]   rd_pa,
    output logic [ATTR_W-1:0] rd_attr,
    output logic [2:0]        rd_size
);

    function automatic logic [VA_W-1:0] va_hi(input logic [2:0] sz);
        return {VA_W{1'b1}} << page_shift(sz);
    endfunction

    function automatic logic [PA_W-1:0] pa_hi(input logic [2:0] sz);
        return {PA_W{1'b1}} << page_shift(sz);
    endfunction

    logic [VA_W-1:0]   e_va     [N];
    logic [PA_W-1:0]   e_pa     [N];
    logic [2:0]        e_size   [N];
    logic              e_global [N];
    logic [ASID_W-1:0] e_asid   [N];
    logic [VMID_W-1:0] e_vmid   [N];
    logic [RG_W-1:0]   e_regime [N];
    logic [ATTR_W-1:0] e_attr   [N];
    logic [N-1:0]      e_vld;

    assign valid_vec = e_vld;

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic inv_hit;

        // Decide whether this cycle's invalidate command removes the entry.
        always_comb begin
            case (inv_cmd_e'(inv_cmd))
                INV_ALL:  inv_hit = 1'b1;
                INV_ASID: inv_hit = !e_global[i] && (e_asid[i] == inv_asid);
                INV_VMID: inv_hit = (e_vmid[i] == inv_vmid);
                default:  inv_hit = 1'b0;
            endcase
        end

        // Valid bit: cleared by reset or invalidate, set by a fill (fill wins).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_vld[i] <= 1'b0;
            end else begin
                if (inv_hit) e_vld[i] <= 1'b0;
                if (wr_en && (wr_idx == IDX_W'(i))) e_vld[i] <= 1'b1;
            end
        end

        // Payload: written on fill, page-aligned; no reset since valid guards it.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                e_va[i]     <= wr_va & va_hi(wr_size);
                e_pa[i]     <= wr_pa & pa_hi(wr_size);
                e_size[i]   <= wr_size;
                e_global[i] <= wr_global;
                e_asid[i]   <= wr_asid;
                e_vmid[i]   <= wr_vmid;
                e_regime[i] <= wr_regime;
                e_attr[i]   <= wr_attr;
            end
        end

        // Lookup compare: page bits under this entry's size plus context tags.
        always_comb begin
            hit_vec[i] = e_vld[i]
                && (((lk_va ^ e_va[i]) & va_hi(e_size[i])) == '0)
                && (e_regime[i] == lk_regime)
                && (e_vmid[i] == lk_vmid)
                && (e_global[i] || (e_asid[i] == lk_asid));
        end

        // Fill compare: same page, size and context means overwrite in place.
        always_comb begin
            dup_vec[i] = e_vld[i]
                && (e_size[i] == wr_size)
                && (((wr_va ^ e_va[i]) & va_hi(wr_size)) == '0)
                && (e_regime[i] == wr_regime)
                && (e_vmid[i] == wr_vmid)
                && (e_global[i] == wr_global)
                && (wr_global || (e_asid[i] == wr_asid));
        end
    end

    // Read mux for the selected hit entry.
    always_comb begin
        rd_pa   = e_pa[rd_idx];
        rd_attr = e_attr[rd_idx];
        rd_size = e_size[rd_idx];
    end

endmodule

// File: rtl/tlb_hit_select.sv
// Lowest-index priority select over the hit vector, with multi-hit flag.
module tlb_hit_select #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hit_vec,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any_hit,
    output logic             multi_hit
);

    // Scan downward so the lowest hitting index is the last assignment.
    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_idx = IDX_W'(i);
        end
    end

    // Any hit, and more than one bit set (clearing the lowest leaves some).
    always_comb begin
        any_hit   = |hit_vec;
        multi_hit = |(hit_vec & (hit_vec - N'(1)));
    end

endmodule

// File: rtl/tlb_victim_pick.sv
// Fill target choice: duplicate entry, else lowest invalid, else the
// round-robin pointer, which moves only when it is consumed.
module tlb_victim_pick #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     dup_vec,
    output logic [IDX_W-1:0] wr_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             use_rr;

    // Lowest duplicate and lowest free slot.
    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup_vec[i])    dup_idx  = IDX_W'(i);
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    // Target priority: duplicate, free, then round-robin.
    always_comb begin
        use_rr = !(|dup_vec) && (&valid_vec);
        if (|dup_vec)        wr_idx = dup_idx;
        else if (!use_rr)    wr_idx = free_idx;
        else                 wr_idx = rr_ptr;
    end

    // Pointer advances, wrapping, only on a round-robin replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_en && use_rr) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tagged_tlb.sv
// Top of the tagged multi-size TLB: parallel compare, lowest-index select,
// PA merge, and a registered response plus miss request one cycle later.
// Assumes PA_W <= VA_W and PA_W covers the largest page offset (29 bits).
module tagged_tlb
    import tagged_tlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16,
    parameter int ATTR_W = 8,
    parameter int RG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic [RG_W-1:0]   lk_regime,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [2:0]        fill_size,
    input  logic              fill_global,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [RG_W-1:0]   fill_regime,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic [1:0]        inv_cmd,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VMID_W-1:0] inv_vmid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              miss_valid,
    output logic [VA_W-1:0]   miss_va,
    output logic [ASID_W-1:0] miss_asid,
    output logic [VMID_W-1:0] miss_vmid,
    output logic [RG_W-1:0]   miss_regime
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [2:0]        fill_sz_n;
    logic [N-1:0]      hit_vec;
    logic [N-1:0]      dup_vec;
    logic [N-1:0]      valid_vec;
    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              any_hit;
    logic              multi_hit;
    logic [PA_W-1:0]   sel_pa;
    logic [ATTR_W-1:0] sel_attr;
    logic [2:0]        sel_size;
    logic [PA_W-1:0]   off_mask;
    logic [PA_W-1:0]   hit_pa;

    assign fill_sz_n = norm_size(fill_size);

    tlb_match_array #(
        .N(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
        .VMID_W(VMID_W), .ATTR_W(ATTR_W), .RG_W(RG_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fill_valid),
        .wr_idx    (wr_idx),
        .wr_va     (fill_va),
        .wr_pa     (fill_pa),
        .wr_size   (fill_sz_n),
        .wr_global (fill_global),
        .wr_asid   (fill_asid),
        .wr_vmid   (fill_vmid),
        .wr_regime (fill_regime),
        .wr_attr   (fill_attr),
        .inv_cmd   (inv_cmd),
        .inv_asid  (inv_asid),
        .inv_vmid  (inv_vmid),
        .lk_va     (lk_va),
        .lk_asid   (lk_asid),
        .lk_vmid   (lk_vmid),
        .lk_regime (lk_regime),
        .rd_idx    (sel_idx),
        .hit_vec   (hit_vec),
        .dup_vec   (dup_vec),
        .valid_vec (valid_vec),
        .rd_pa     (sel_pa),
        .rd_attr   (sel_attr),
        .rd_size   (sel_size)
    );

    tlb_hit_select #(.N(N)) u_select (
        .hit_vec   (hit_vec),
        .sel_idx   (sel_idx),
        .any_hit   (any_hit),
        .multi_hit (multi_hit)
    );

    tlb_victim_pick #(.N(N)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_valid),
        .valid_vec (valid_vec),
        .dup_vec   (dup_vec),
        .wr_idx    (wr_idx)
    );

    // Merge page bits from the entry with offset bits from the request.
    always_comb begin
        off_mask = ~({PA_W{1'b1}} << page_shift(sel_size));
        hit_pa   = (sel_pa & ~off_mask) | (lk_va[PA_W-1:0] & off_mask);
    end

    // Register the response and the miss request one cycle after lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_multi   <= 1'b0;
            rsp_pa      <= '0;
            rsp_attr    <= '0;
            miss_valid  <= 1'b0;
            miss_va     <= '0;
            miss_asid   <= '0;
            miss_vmid   <= '0;
            miss_regime <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && any_hit;
            rsp_multi  <= lk_valid && multi_hit;
            rsp_pa     <= (lk_valid && any_hit) ? hit_pa : '0;
            rsp_attr   <= (lk_valid && any_hit) ? sel_attr : '0;
            miss_valid <= lk_valid && !any_hit;
            if (lk_valid) begin
                miss_va     <= lk_va;
                miss_asid   <= lk_asid;
                miss_vmid   <= lk_vmid;
                miss_regime <= lk_regime;
            end
        end
    end

endmodule

// File: rtl/tagged_tlb_chk.sv
// Assertion checker for tagged_tlb, bound to every instance of the top.
module tagged_tlb_chk #(
    parameter int N      = 8,
    parameter int VA_W   = 48,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16,
    parameter int RG_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_va,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VMID_W-1:0] lk_vmid,
    input logic [RG_W-1:0]   lk_regime,
    input logic              fill_valid,
    input logic [1:0]        inv_cmd,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_multi,
    input logic              miss_valid,
    input logic [VA_W-1:0]   miss_va,
    input logic [ASID_W-1:0] miss_asid,
    input logic [VMID_W-1:0] miss_vmid,
    input logic [RG_W-1:0]   miss_regime,
    input logic [N-1:0]      valid_vec,
    input logic [N-1:0]      hit_vec
);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_miss_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (rsp_valid && !rsp_hit));

    assert_miss_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (miss_va == $past(lk_va) && miss_asid == $past(lk_asid)
                        && miss_vmid == $past(lk_vmid) && miss_regime == $past(lk_regime)));

    assert_inv_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_cmd == 2'd1 && !fill_valid) |=> (valid_vec == '0));

    assert_multi_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $countones(hit_vec) > 1) |=> rsp_multi);

    assert_multi_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

endmodule

bind tagged_tlb tagged_tlb_chk #(
    .N(N), .VA_W(VA_W), .ASID_W(ASID_W), .VMID_W(VMID_W), .RG_W(RG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_va       (lk_va),
    .lk_asid     (lk_asid),
    .lk_vmid     (lk_vmid),
    .lk_regime   (lk_regime),
    .fill_valid  (fill_valid),
    .inv_cmd     (inv_cmd),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_multi   (rsp_multi),
    .miss_valid  (miss_valid),
    .miss_va     (miss_va),
    .miss_asid   (miss_asid),
    .miss_vmid   (miss_vmid),
    .miss_regime (miss_regime),
    .valid_vec   (valid_vec),
    .hit_vec     (hit_vec)
);

// File: tb/sim_tagged_tlb.sv
// Bench for tagged_tlb: directed corner cases followed by seeded random
// traffic, every response compared with a bench model of the table.
module sim_tagged_tlb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic [15:0] lk_asid = '0;
    logic [15:0] lk_vmid = '0;
    logic [1:0]  lk_regime = '0;
    logic        fill_valid = 1'b0;
    logic [47:0] fill_va = '0;
    logic [39:0] fill_pa = '0;
    logic [2:0]  fill_size = '0;
    logic        fill_global = 1'b0;
    logic [15:0] fill_asid = '0;
    logic [15:0] fill_vmid = '0;
    logic [1:0]  fill_regime = '0;
    logic [7:0]  fill_attr = '0;
    logic [1:0]  inv_cmd = '0;
    logic [15:0] inv_asid = '0;
    logic [15:0] inv_vmid = '0;
    logic        rsp_valid, rsp_hit, rsp_multi, miss_valid;
    logic [39:0] rsp_pa;
    logic [7:0]  rsp_attr;
    logic [47:0] miss_va;
    logic [15:0] miss_asid, miss_vmid;
    logic [1:0]  miss_regime;

    always #5 clk = ~clk;

    tagged_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_vmid(lk_vmid), .lk_regime(lk_regime),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_size(fill_size), .fill_global(fill_global), .fill_asid(fill_asid),
        .fill_vmid(fill_vmid), .fill_regime(fill_regime), .fill_attr(fill_attr),
        .inv_cmd(inv_cmd), .inv_asid(inv_asid), .inv_vmid(inv_vmid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
        .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .miss_valid(miss_valid),
        .miss_va(miss_va), .miss_asid(miss_asid), .miss_vmid(miss_vmid),
        .miss_regime(miss_regime)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the table.
    bit          m_vld  [N];
    logic [47:0] m_va   [N];
    logic [39:0] m_pa   [N];
    logic [2:0]  m_sz   [N];
    bit          m_g    [N];
    logic [15:0] m_asid [N];
    logic [15:0] m_vmid [N];
    logic [1:0]  m_rg   [N];
    logic [7:0]  m_attr [N];
    int          m_ptr = 0;

    function automatic int f_shift(input logic [2:0] sz);
        case (sz)
            3'd1: return 14;
            3'd2: return 16;
            3'd3: return 21;
            3'd4: return 29;
            default: return 12;
        endcase
    endfunction

    function automatic logic [47:0] f_hi48(input logic [2:0] sz);
        return ~48'h0 << f_shift(sz);
    endfunction

    function automatic logic [39:0] f_lo40(input logic [2:0] sz);
        return ~(~40'h0 << f_shift(sz));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_fill(input logic [47:0] va, input logic [39:0] pa,
                           input logic [2:0] sz, input bit g, input logic [15:0] asid,
                           input logic [15:0] vmid, input logic [1:0] rg,
                           input logic [7:0] attr);
        logic [2:0] szn;
        int tgt;
        szn = (sz > 3'd4) ? 3'd0 : sz;
        tgt = -1;
        for (int i = 0; i < N; i++) begin
            if (tgt < 0 && m_vld[i] && m_sz[i] == szn && m_rg[i] == rg
                && m_vmid[i] == vmid && m_g[i] == g && (g || m_asid[i] == asid)
                && ((va ^ m_va[i]) & f_hi48(szn)) == '0) tgt = i;
        end
        for (int i = 0; i < N; i++) begin
            if (tgt < 0 && !m_vld[i]) tgt = i;
        end
        if (tgt < 0) begin
            tgt = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_vld[tgt] = 1'b1;  m_va[tgt] = va & f_hi48(szn);
        m_pa[tgt] = pa & ~f_lo40(szn);  m_sz[tgt] = szn;
        m_g[tgt] = g;  m_asid[tgt] = asid;  m_vmid[tgt] = vmid;
        m_rg[tgt] = rg;  m_attr[tgt] = attr;
        @(negedge clk);
        fill_valid = 1'b1;  fill_va = va;  fill_pa = pa;  fill_size = sz;
        fill_global = g;  fill_asid = asid;  fill_vmid = vmid;
        fill_regime = rg;  fill_attr = attr;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [1:0] cmd, input logic [15:0] asid,
                          input logic [15:0] vmid);
        for (int i = 0; i < N; i++) begin
            if (cmd == 2'd1) m_vld[i] = 1'b0;
            if (cmd == 2'd2 && !m_g[i] && m_asid[i] == asid) m_vld[i] = 1'b0;
            if (cmd == 2'd3 && m_vmid[i] == vmid) m_vld[i] = 1'b0;
        end
        @(negedge clk);
        inv_cmd = cmd;  inv_asid = asid;  inv_vmid = vmid;
        @(negedge clk);
        inv_cmd = 2'd0;
    endtask

    task automatic do_look(input string req, input logic [47:0] va,
                           input logic [15:0] asid, input logic [15:0] vmid,
                           input logic [1:0] rg);
        int first;
        int cnt;
        logic [39:0] e_pa;
        first = -1;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && ((va ^ m_va[i]) & f_hi48(m_sz[i])) == '0
                && m_rg[i] == rg && m_vmid[i] == vmid && (m_g[i] || m_asid[i] == asid)) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        @(negedge clk);
        lk_valid = 1'b1;  lk_va = va;  lk_asid = asid;  lk_vmid = vmid;  lk_regime = rg;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(req, "rsp_hit", 64'(rsp_hit), 64'(first >= 0));
        chk(req, "rsp_multi", 64'(rsp_multi), 64'(cnt > 1));
        chk(req, "miss_valid", 64'(miss_valid), 64'(first < 0));
        if (first >= 0) begin
            e_pa = (m_pa[first] & ~f_lo40(m_sz[first])) | (va[39:0] & f_lo40(m_sz[first]));
            chk(req, "rsp_pa", 64'(rsp_pa), 64'(e_pa));
            chk(req, "rsp_attr", 64'(rsp_attr), 64'(m_attr[first]));
        end else begin
            chk(req, "miss_va", 64'(miss_va), 64'(va));
            chk(req, "miss_ctx", {28'h0, miss_asid, miss_vmid, 2'b0, miss_regime},
                {28'h0, asid, vmid, 2'b0, rg});
        end
    endtask

    function automatic logic [47:0] rnd_va();
        return (48'($urandom % 4) << 29) | (48'($urandom % 4) << 21)
             | (48'($urandom % 4) << 16) | (48'($urandom % 4) << 12)
             | 48'($urandom % 4096);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1", "miss_valid after reset", 64'(miss_valid), 64'd0);
        do_look("R1", 48'h0000_1234_5678, 16'd1, 16'd0, 2'd0);
        // R8 R4: 4KB fill visible next cycle, PA merge
        do_fill(48'h0000_1234_5000, 40'h00_ABCD_E000, 3'd0, 1'b0, 16'd1, 16'd0, 2'd0, 8'h5A);
        do_look("R8", 48'h0000_1234_5678, 16'd1, 16'd0, 2'd0);
        do_look("R3", 48'h0000_1234_6678, 16'd1, 16'd0, 2'd0);
        // R3: 2MB and 512MB pages, reserved size code
        do_fill(48'h0000_4060_0000, 40'h12_3440_0000, 3'd3, 1'b0, 16'd1, 16'd0, 2'd0, 8'h21);
        do_look("R4", 48'h0000_407F_F123, 16'd1, 16'd0, 2'd0);
        do_look("R3", 48'h0000_4080_0000, 16'd1, 16'd0, 2'd0);
        do_fill(48'h0000_6000_0000, 40'h00_2000_0000, 3'd4, 1'b0, 16'd1, 16'd0, 2'd0, 8'h44);
        do_look("R3", 48'h0000_7ABC_DEF0, 16'd1, 16'd0, 2'd0);
        do_fill(48'h0000_7777_7000, 40'h00_0555_5000, 3'd6, 1'b0, 16'd1, 16'd0, 2'd0, 8'h66);
        do_look("R3", 48'h0000_7777_8000, 16'd1, 16'd0, 2'd0);
        do_look("R3", 48'h0000_7777_7FFF, 16'd1, 16'd0, 2'd0);
        // R5: ASID and global
        do_look("R5", 48'h0000_1234_5000, 16'd2, 16'd0, 2'd0);
        do_fill(48'h0000_0888_0000, 40'h00_0999_0000, 3'd2, 1'b1, 16'd3, 16'd0, 2'd0, 8'h77);
        do_look("R5", 48'h0000_0888_1234, 16'd1, 16'd0, 2'd0);
        do_look("R5", 48'h0000_0888_F234, 16'd2, 16'd0, 2'd0);
        // R6: VMID and regime
        do_look("R6", 48'h0000_1234_5000, 16'd1, 16'd1, 2'd0);
        do_look("R6", 48'h0000_1234_5000, 16'd1, 16'd0, 2'd1);
        // R11: 4KB page inside the 2MB page
        do_fill(48'h0000_4060_3000, 40'h00_0BAD_0000, 3'd0, 1'b0, 16'd1, 16'd0, 2'd0, 8'h99);
        do_look("R11", 48'h0000_4060_3010, 16'd1, 16'd0, 2'd0);
        // R9: duplicate fill overwrites in place
        do_fill(48'h0000_1234_5000, 40'h00_FEED_F000, 3'd0, 1'b0, 16'd1, 16'd0, 2'd0, 8'h3C);
        do_look("R9", 48'h0000_1234_5ABC, 16'd1, 16'd0, 2'd0);
        // R10: invalidate by ASID, VMID, all
        do_inv(2'd2, 16'd1, 16'd0);
        do_look("R10", 48'h0000_1234_5000, 16'd1, 16'd0, 2'd0);
        do_look("R10", 48'h0000_0888_0000, 16'd1, 16'd0, 2'd0);
        do_fill(48'h0000_0100_0000, 40'h00_0200_0000, 3'd0, 1'b1, 16'd1, 16'd1, 2'd0, 8'h01);
        do_inv(2'd3, 16'd0, 16'd1);
        do_look("R10", 48'h0000_0100_0000, 16'd1, 16'd1, 2'd0);
        do_inv(2'd0, 16'd3, 16'd0);
        do_look("R10", 48'h0000_0888_0000, 16'd1, 16'd0, 2'd0);
        do_inv(2'd1, 16'd0, 16'd0);
        do_look("R10", 48'h0000_0888_0000, 16'd1, 16'd0, 2'd0);
        // R9: fill past capacity, round-robin eviction
        for (int k = 0; k < N + 3; k++)
            do_fill(48'h0000_0050_0000 + 48'(k) * 48'h1000, 40'h00_0700_0000 + 40'(k) * 40'h1000,
                    3'd0, 1'b0, 16'd5, 16'd0, 2'd0, 8'(k));
        for (int k = 0; k < N + 3; k++)
            do_look("R9", 48'h0000_0050_0000 + 48'(k) * 48'h1000 + 48'h10, 16'd5, 16'd0, 2'd0);
        // R2: response only follows a lookup
        @(negedge clk);
        chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
        // Random traffic
        for (int k = 0; k < 1500; k++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 2)
                do_fill(rnd_va(), {8'h0, $urandom}, 3'($urandom % 6), ($urandom % 4) == 0,
                        16'($urandom % 2 + 1), 16'($urandom % 2), 2'($urandom % 2), 8'($urandom));
            else if (op == 2 && ($urandom % 8) == 0)
                do_inv(2'($urandom % 4), 16'($urandom % 2 + 1), 16'($urandom % 2));
            else
                do_look("R11", rnd_va(), 16'($urandom % 2 + 1), 16'($urandom % 2), 2'($urandom % 2));
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule